// File: doc/BRIEF.md
# Indirect Register Access Port

This block lets a narrow 16-bit host window reach two internal targets that it cannot address directly: a file of 16-bit control registers and a word-addressed memory whose words are 24 bits wide. Each target has its own pair of host registers. The first register of the pair holds the target address and the transfer direction. The second holds the data. The host never presents a target address on its own bus. It loads the address register and then moves the value through the data register.

A read starts when the host writes the address register with the read bit set. One cycle later the block drives a one-cycle strobe toward the target. At the end of that cycle it captures the returned word into the data register. A write starts when the host writes the data register while the stored direction is write. The memory path also stores a width select. In 24-bit mode the top byte of the word is staged in a separate host register. In 16-bit mode the top byte of the memory word is left untouched on a write and is returned as zero on a read. The host has no byte-wide access to the memory. A status register shows which path still has a transfer pending.

Top module: `iap_port`

## Requirements
- R1: Control address register, host offset 0: bits [CR_AW-1:0] hold the register address and bit 15 is the direction (1 = read). Reading offset 0 returns the stored address and direction.
- R2: Writing offset 0 with bit 15 = 1 drives `creg_req` high with `creg_we` = 0 for exactly one cycle, in the cycle after the host write. After that cycle, the control data register at offset 1 holds `creg_rdata`.
- R3: If the stored control direction is write, a host write to offset 1 loads the data register. In the next cycle it drives one `creg_req` pulse with `creg_we` = 1, the stored address and the new data.
- R4: Memory address register, host offset 2: bits [MEM_AW-1:0] hold the word address, bit 15 is the direction (1 = read) and bit 14 is the width (1 = 24-bit, 0 = 16-bit). Reading offset 2 returns these fields.
- R5: A write to offset 4 loads memory data bits [23:16] from host bits [7:0] and starts no transfer. A write to offset 3 loads bits [15:0]. If the memory direction is write, the offset 3 write also issues one `mem_req` pulse with `mem_we` = 1 in the next cycle, carrying the full 24-bit data register.
- R6: A memory write drives `mem_wmask` = 2'b11 in 24-bit mode and 2'b01 in 16-bit mode. Bit 0 enables bits [15:0] and bit 1 enables bits [23:16], so a 16-bit write leaves the top byte of the memory word unchanged.
- R7: Writing offset 2 with bit 15 = 1 issues one `mem_req` pulse with `mem_we` = 0 in the next cycle. In 24-bit mode the whole returned word is then readable: bits [15:0] at offset 3 and bits [23:16] in the low byte of offset 4.
- R8: A memory read in 16-bit mode stores the low 16 returned bits and clears data bits [23:16].
- R9: Status at offset 5: bit 0 is 1 while a control transfer is pending and bit 1 is 1 while a memory transfer is pending. Each bit is 1 exactly in the strobe cycle of its path and 0 otherwise.
- R10: While a path's transfer is pending, host writes to that path's address and data registers are ignored. A read result captured in that cycle is kept.
- R11: A data register write while the direction is read, and an address write with the direction set to write, start no transfer.
- R12: After reset, all host registers read zero, both status bits are zero and no strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one word per cycle |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` (combinational) |
| creg_req | output | 1 | Control register transfer strobe |
| creg_we | output | 1 | Control register write enable |
| creg_addr | output | CR_AW | Control register address |
| creg_wdata | output | 16 | Control register write data |
| creg_rdata | input | 16 | Control register read data, valid in the strobe cycle |
| mem_req | output | 1 | Memory transfer strobe |
| mem_we | output | 1 | Memory write enable |
| mem_wmask | output | 2 | Lane enables: bit 0 for [15:0], bit 1 for [23:16] |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, valid in the strobe cycle |

## Verification
Two events can fall in one cycle: a memory read capture, and a host write to the same path's address or data register while the strobe is still outstanding. The bench provokes this by holding the host write strobe for two cycles. The first write starts a read and the second targets the busy path with a different address or data value. The result is judged at the ports. The data register must hold the word from the first address, the address register must still show that address, and the strobe counter must have moved by exactly one.

// File: rtl/iap_pkg.sv
package iap_pkg;
  localparam int HOST_AW = 3;
  localparam int MEM_DW  = 24;
  localparam int HOST_DW = 16;
  localparam int HI_W    = MEM_DW - HOST_DW;

  localparam logic [HOST_AW-1:0] OFF_CADDR = 3'd0;
  localparam logic [HOST_AW-1:0] OFF_CDATA = 3'd1;
  localparam logic [HOST_AW-1:0] OFF_MADDR = 3'd2;
  localparam logic [HOST_AW-1:0] OFF_MLO   = 3'd3;
  localparam logic [HOST_AW-1:0] OFF_MHI   = 3'd4;
  localparam logic [HOST_AW-1:0] OFF_STAT  = 3'd5;

  localparam int DIR_BIT  = 15;
  localparam int WIDE_BIT = 14;

  // Word placed in the memory data register after a read
  function automatic logic [MEM_DW-1:0] mem_capture(input logic [MEM_DW-1:0] rd,
                                                    input logic wide);
    return wide ? rd : {{HI_W{1'b0}}, rd[HOST_DW-1:0]};
  endfunction

  // Lane enables for a memory write
  function automatic logic [1:0] mem_lanes(input logic wide);
    return {wide, 1'b1};
  endfunction
endpackage

// File: rtl/iap_creg_path.sv
module iap_creg_path #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_data,
  input  logic [15:0]   wdata,
  input  logic [15:0]   be_rdata,
  output logic [AW-1:0] addr_q,
  output logic          rd_q,
  output logic [15:0]   data_q,
  output logic          pend_q,
  output logic          start,
  output logic          capture
);
  logic ld_addr, ld_data;
  logic unused_bits;

  assign ld_addr = wr_addr & ~pend_q;
  assign ld_data = wr_data & ~pend_q;
  assign start   = (ld_addr & wdata[iap_pkg::DIR_BIT]) | (ld_data & ~rd_q);
  assign capture = pend_q & rd_q;
  assign unused_bits = ^wdata[iap_pkg::DIR_BIT-1:AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= start;
      if (ld_addr) begin
        addr_q <= wdata[AW-1:0];
        rd_q   <= wdata[iap_pkg::DIR_BIT];
      end
      if (capture)      data_q <= be_rdata;
      else if (ld_data) data_q <= wdata;
    end
  end
endmodule

// File: rtl/iap_mem_path.sv
module iap_mem_path #(
  parameter int AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_addr,
  input  logic                      wr_lo,
  input  logic                      wr_hi,
  input  logic [15:0]               wdata,
  input  logic [iap_pkg::MEM_DW-1:0] be_rdata,
  output logic [AW-1:0]             addr_q,
  output logic                      rd_q,
  output logic                      wide_q,
  output logic [iap_pkg::MEM_DW-1:0] data_q,
  output logic                      pend_q,
  output logic                      start,
  output logic                      capture
);
  import iap_pkg::*;
  logic ld_addr, ld_lo, ld_hi;
  logic unused_bits;

  assign ld_addr = wr_addr & ~pend_q;
  assign ld_lo   = wr_lo & ~pend_q;
  assign ld_hi   = wr_hi & ~pend_q;
  assign start   = (ld_addr & wdata[DIR_BIT]) | (ld_lo & ~rd_q);
  assign capture = pend_q & rd_q;
  assign unused_bits = ^wdata[WIDE_BIT-1:AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      wide_q <= 1'b0;
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= start;
      if (ld_addr) begin
        addr_q <= wdata[AW-1:0];
        rd_q   <= wdata[DIR_BIT];
        wide_q <= wdata[WIDE_BIT];
      end
      if (capture) begin
        data_q <= mem_capture(be_rdata, wide_q);
      end else begin
        if (ld_lo) data_q[HOST_DW-1:0]      <= wdata;
        if (ld_hi) data_q[MEM_DW-1:HOST_DW] <= wdata[HI_W-1:0];
      end
    end
  end
endmodule

// File: rtl/iap_rd_mux.sv
module iap_rd_mux #(
  parameter int CR_AW  = 6,
  parameter int MEM_AW = 8
) (
  input  logic [iap_pkg::HOST_AW-1:0] sel,
  input  logic [CR_AW-1:0]            c_addr,
  input  logic                        c_rd,
  input  logic [15:0]                 c_data,
  input  logic                        c_busy,
  input  logic [MEM_AW-1:0]           m_addr,
  input  logic                        m_rd,
  input  logic                        m_wide,
  input  logic [iap_pkg::MEM_DW-1:0]  m_data,
  input  logic                        m_busy,
  output logic [15:0]                 rdata
);
  import iap_pkg::*;
  always_comb begin
    rdata = '0;
    case (sel)
      OFF_CADDR: begin
        rdata[CR_AW-1:0] = c_addr;
        rdata[DIR_BIT]   = c_rd;
      end
      OFF_CDATA: rdata = c_data;
      OFF_MADDR: begin
        rdata[MEM_AW-1:0] = m_addr;
        rdata[DIR_BIT]    = m_rd;
        rdata[WIDE_BIT]   = m_wide;
      end
      OFF_MLO:  rdata = m_data[HOST_DW-1:0];
      OFF_MHI:  rdata[HI_W-1:0] = m_data[MEM_DW-1:HOST_DW];
      OFF_STAT: rdata[1:0] = {m_busy, c_busy};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/iap_port.sv
module iap_port #(
  parameter int CR_AW  = 6,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              creg_req,
  output logic              creg_we,
  output logic [CR_AW-1:0]  creg_addr,
  output logic [15:0]       creg_wdata,
  input  logic [15:0]       creg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_wmask,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [23:0]       mem_wdata,
  input  logic [23:0]       mem_rdata
);
  import iap_pkg::*;

  // Host decode events
  logic wr_caddr, wr_cdata, wr_maddr, wr_mlo, wr_mhi;
  assign wr_caddr = host_wr & (host_addr == OFF_CADDR);
  assign wr_cdata = host_wr & (host_addr == OFF_CDATA);
  assign wr_maddr = host_wr & (host_addr == OFF_MADDR);
  assign wr_mlo   = host_wr & (host_addr == OFF_MLO);
  assign wr_mhi   = host_wr & (host_addr == OFF_MHI);

  // Path state and events brought out for checking
  logic [CR_AW-1:0]  c_addr_q;
  logic              c_rd_q, c_busy, c_start, c_capture;
  logic [15:0]       c_data_q;
  logic [MEM_AW-1:0] m_addr_q;
  logic              m_rd_q, m_wide_q, m_busy, m_start, m_capture;
  logic [23:0]       m_data_q;

  iap_creg_path #(.AW(CR_AW)) u_creg (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(wr_caddr), .wr_data(wr_cdata), .wdata(host_wdata),
    .be_rdata(creg_rdata),
    .addr_q(c_addr_q), .rd_q(c_rd_q), .data_q(c_data_q), .pend_q(c_busy),
    .start(c_start), .capture(c_capture)
  );

  iap_mem_path #(.AW(MEM_AW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(wr_maddr), .wr_lo(wr_mlo), .wr_hi(wr_mhi), .wdata(host_wdata),
    .be_rdata(mem_rdata),
    .addr_q(m_addr_q), .rd_q(m_rd_q), .wide_q(m_wide_q), .data_q(m_data_q),
    .pend_q(m_busy), .start(m_start), .capture(m_capture)
  );

  iap_rd_mux #(.CR_AW(CR_AW), .MEM_AW(MEM_AW)) u_mux (
    .sel(host_addr),
    .c_addr(c_addr_q), .c_rd(c_rd_q), .c_data(c_data_q), .c_busy(c_busy),
    .m_addr(m_addr_q), .m_rd(m_rd_q), .m_wide(m_wide_q), .m_data(m_data_q),
    .m_busy(m_busy), .rdata(host_rdata)
  );

  // Backend strobes
  assign creg_req   = c_busy;
  assign creg_we    = ~c_rd_q;
  assign creg_addr  = c_addr_q;
  assign creg_wdata = c_data_q;

  assign mem_req    = m_busy;
  assign mem_we     = ~m_rd_q;
  assign mem_wmask  = mem_lanes(m_wide_q);
  assign mem_addr   = m_addr_q;
  assign mem_wdata  = m_data_q;
endmodule

// File: rtl/iap_port_chk.sv
module iap_port_chk #(
  parameter int CR_AW  = 6,
  parameter int MEM_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              c_start,
  input logic              m_start,
  input logic              creg_req,
  input logic              mem_req,
  input logic              mem_we,
  input logic [1:0]        mem_wmask,
  input logic              m_wide_q,
  input logic [23:0]       m_data_q,
  input logic [23:0]       mem_rdata,
  input logic [MEM_AW-1:0] m_addr_q,
  input logic              wr_maddr,
  input logic              wr_mlo
);
  // R2
  c_strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_start |=> creg_req);
  // R2
  c_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    creg_req |=> !creg_req);
  // R7
  m_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R9
  m_strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(m_start));
  // R6
  m_narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !m_wide_q) |-> (mem_wmask == 2'b01));
  // R8
  m_narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !m_wide_q) |=> (m_data_q[23:16] == 8'h00));
  // R10
  m_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && wr_maddr) |=> $stable(m_addr_q));
  // R10
  m_capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && m_wide_q && wr_mlo) |=> (m_data_q == $past(mem_rdata)));
endmodule

bind iap_port iap_port_chk #(.CR_AW(CR_AW), .MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .c_start(c_start), .m_start(m_start),
  .creg_req(creg_req), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wmask(mem_wmask), .m_wide_q(m_wide_q), .m_data_q(m_data_q),
  .mem_rdata(mem_rdata), .m_addr_q(m_addr_q), .wr_maddr(wr_maddr),
  .wr_mlo(wr_mlo)
);

// File: tb/iap_port_tb.sv
module iap_port_tb;
  localparam int CA = 6;
  localparam int MA = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic creg_req, creg_we, mem_req, mem_we;
  logic [CA-1:0] creg_addr;
  logic [15:0] creg_wdata, creg_rdata;
  logic [1:0] mem_wmask;
  logic [MA-1:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int c_pulses = 0;
  int m_pulses = 0;

  always #2.5 clk = ~clk;

  iap_port #(.CR_AW(CA), .MEM_AW(MA)) u_dut (.*);

  // Backend models
  logic [15:0] cfile [1<<CA];
  logic [23:0] mfile [1<<MA];
  assign creg_rdata = cfile[creg_addr];
  assign mem_rdata  = mfile[mem_addr];
  always @(posedge clk) begin
    if (creg_req) c_pulses <= c_pulses + 1;
    if (mem_req)  m_pulses <= m_pulses + 1;
    if (creg_req && creg_we) cfile[creg_addr] <= creg_wdata;
    if (mem_req && mem_we) begin
      if (mem_wmask[0]) mfile[mem_addr][15:0]  <= mem_wdata[15:0];
      if (mem_wmask[1]) mfile[mem_addr][23:16] <= mem_wdata[23:16];
    end
  end

  function automatic logic [15:0] cpat(input int a);
    return 16'((a * 16'h1D3) ^ 16'hC35A);
  endfunction
  function automatic logic [23:0] mpat(input int a);
    return 24'((a * 24'h9E37 + 24'h5A1) ^ (a << 17));
  endfunction
  function automatic logic [15:0] npat(input int a);
    return 16'((a * 16'h3C5) ^ 16'hA5A5);
  endfunction
  function automatic logic [23:0] mexp(input int a);
    return (a % 2 == 0) ? {mpat(a)[23:16], npat(a)} : mpat(a);
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hw2(input logic [2:0] a1, input logic [15:0] d1,
                     input logic [2:0] a2, input logic [15:0] d2);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a1; host_wdata = d1;
    @(negedge clk);
    host_addr = a2; host_wdata = d2;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [15:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r, r2;
    int cp, mp;
    // R12 reset state
    repeat (3) @(negedge clk);
    for (int o = 0; o < 6; o++) begin
      hr(3'(o), r);
      check("R12 reg zero", {8'h0, r}, 24'h0);
    end
    check("R12 no strobe", {22'h0, creg_req, mem_req}, 24'h0);
    rst_n = 1'b1;

    // R3 control writes over all addresses, R1 readback
    for (int a = 0; a < (1 << CA); a++) begin
      hw(3'd0, 16'(a));
      hr(3'd0, r);
      check("R1 addr readback", {8'h0, r}, 24'(a));
      cp = c_pulses;
      hw(3'd1, cpat(a));
      check("R3 strobe write", {21'h0, creg_req, creg_we, 1'b0}, 24'h6);
      check("R3 strobe addr", 24'(creg_addr), 24'(a));
      check("R3 strobe data", {8'h0, creg_wdata}, {8'h0, cpat(a)});
      hr(3'd5, r);
      check("R9 creg busy", {8'h0, r}, 24'h1);
      @(negedge clk);
      check("R3 one pulse", 24'(c_pulses - cp), 24'd1);
      hr(3'd5, r);
      check("R9 idle", {8'h0, r}, 24'h0);
    end
    check("R11 addr write no strobe", 24'(c_pulses), 24'(1 << CA));

    // R2 control reads over all addresses
    for (int a = (1 << CA) - 1; a >= 0; a--) begin
      hw(3'd0, 16'h8000 | 16'(a));
      check("R2 read strobe", {22'h0, creg_req, creg_we}, 24'h2);
      @(negedge clk);
      hr(3'd1, r);
      check("R2 read data", {8'h0, r}, {8'h0, cpat(a)});
      hr(3'd0, r);
      check("R1 dir readback", {8'h0, r}, {8'h0, 16'h8000 | 16'(a)});
    end

    // R11 data write with read direction
    cp = c_pulses;
    hw(3'd1, 16'hBEEF);
    @(negedge clk);
    check("R11 no strobe on data", 24'(c_pulses - cp), 24'd0);
    hr(3'd1, r);
    check("R11 data loaded", {8'h0, r}, 24'hBEEF);

    // R5 24-bit memory writes over all words
    for (int a = 0; a < (1 << MA); a++) begin
      hw(3'd2, 16'h4000 | 16'(a));
      hr(3'd2, r);
      check("R4 mem addr readback", {8'h0, r}, {8'h0, 16'h4000 | 16'(a)});
      mp = m_pulses;
      hw(3'd4, {8'h0, mpat(a)[23:16]});
      check("R5 hi no strobe", {23'h0, mem_req}, 24'h0);
      hw(3'd3, mpat(a)[15:0]);
      check("R5 strobe", {21'h0, mem_req, mem_we, 1'b0}, 24'h6);
      check("R6 wide mask", {22'h0, mem_wmask}, 24'h3);
      check("R5 wdata", mem_wdata, mpat(a));
      hr(3'd5, r);
      check("R9 mem busy", {8'h0, r}, 24'h2);
      @(negedge clk);
      check("R5 one pulse", 24'(m_pulses - mp), 24'd1);
    end

    // R6 16-bit writes to even words
    for (int a = 0; a < (1 << MA); a += 2) begin
      hw(3'd2, 16'(a));
      hw(3'd4, 16'h00FF);
      hw(3'd3, npat(a));
      check("R6 narrow mask", {22'h0, mem_wmask}, 24'h1);
      @(negedge clk);
    end

    // R7 24-bit reads
    for (int a = 0; a < (1 << MA); a++) begin
      hw(3'd2, 16'hC000 | 16'(a));
      check("R7 read strobe", {22'h0, mem_req, mem_we}, 24'h2);
      @(negedge clk);
      hr(3'd3, r);
      hr(3'd4, r2);
      check("R7 wide word", {r2[7:0], r}, mexp(a));
      check("R6 upper kept", {r2[7:0], 16'h0}, {mexp(a)[23:16], 16'h0});
    end

    // R8 16-bit reads
    for (int a = 0; a < (1 << MA); a++) begin
      hw(3'd2, 16'h8000 | 16'(a));
      @(negedge clk);
      hr(3'd3, r);
      hr(3'd4, r2);
      check("R8 narrow word", {r2[7:0], r}, {8'h0, mexp(a)[15:0]});
    end

    // R10 data write in capture cycle
    mp = m_pulses;
    hw2(3'd2, 16'hC000 | 16'd5, 3'd3, 16'h1234);
    hr(3'd3, r);
    hr(3'd4, r2);
    check("R10 capture wins", {r2[7:0], r}, mexp(5));
    check("R10 one pulse", 24'(m_pulses - mp), 24'd1);
    // R10 address write while pending
    mp = m_pulses;
    hw2(3'd2, 16'hC000 | 16'd9, 3'd2, 16'hC000 | 16'd200);
    hr(3'd2, r);
    check("R10 addr kept", {8'h0, r}, {8'h0, 16'hC000 | 16'd9});
    hr(3'd3, r);
    hr(3'd4, r2);
    check("R10 first word", {r2[7:0], r}, mexp(9));
    check("R10 single strobe", 24'(m_pulses - mp), 24'd1);
    // R10 control path
    cp = c_pulses;
    hw2(3'd0, 16'h8000 | 16'd7, 3'd1, 16'h5555);
    hr(3'd1, r);
    check("R10 creg capture wins", {8'h0, r}, {8'h0, cpat(7)});
    check("R10 creg one pulse", 24'(c_pulses - cp), 24'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule